// File: doc/BRIEF.md
# Cascadable Serial-Load Parallel Driver with Transparent Strobe

This block turns a slow three-wire serial stream into 24 parallel output bits. A host toggles a shift clock and presents one data bit per rising edge. Each edge moves the word one stage deeper into a 24-stage shift register, and the last stage leaves the block on a cascade pin. That pin feeds the serial input of the next device in a chain. Between the shift register and the outputs sits a latch that is transparent while the active-low strobe is held low and frozen while it is high. An active-low clear forces every latch bit to one and leaves the shift register alone.

The four host pins are asynchronous to the block. They are sampled by a fast system clock through synchronisers. A two-state edge detector (`CK_LOW`, `CK_HIGH`) turns each rising shift-clock edge into one shift pulse. Its transitions are rise (`CK_LOW`→`CK_HIGH`, which emits the pulse) and fall (`CK_HIGH`→`CK_LOW`). A three-state latch controller selects what the outputs do:
- `LAT_CLEAR`: entered asynchronously whenever clear or system reset is active.
- `LAT_FOLLOW`: entered on the next system clock when the synchronised strobe is low.
- `LAT_HOLD`: entered on the next system clock when the synchronised strobe is high.

From any state, the transitions follow, hold and clear are taken by those rules.

Top module: `cascade_sipo_driver`

## Requirements
- R1: Shift stage k drives `par_o[k]`, and stage 0 takes the serial input. After 24 shift-clock rising edges, the first bit sent sits in `par_o[23]`. A word sent most significant bit first therefore appears unchanged on `par_o` once it is strobed.
- R2: Each rising edge of `sclk_i` produces exactly one shift. Stage 0 takes `sdata_i`, and stage k takes the old stage k-1. Falling edges and steady levels leave the register unchanged.
- R3: While `stb_ni` is low and clear is inactive, `par_o` follows the shift register, including every single shift.
- R4: While `stb_ni` is high, `par_o` holds its value whatever shifting takes place.
- R5: While `clr_ni` is low, `par_o` is all ones at once, without waiting for a system clock edge. This overrides a low strobe. After release the ones remain until the strobe next goes low.
- R6: Clear does not alter the shift register. Bits shifted before and during clear show up on `par_o` at the next strobe.
- R7: `sout_o` presents stage 23. It changes only on shifts, whatever the strobe and clear do.
- R8: With `sout_o` of one device wired to `sdata_i` of a second, 48 shift edges and one strobe load both devices. The first bit lands in bit 23 of the downstream device, and bit 24 of the stream lands in bit 23 of the upstream device.
- R9: After system reset the shift register is zero, `sout_o` is 0 and `par_o` is all ones.
- R10: A new `sout_o` value appears on the third system clock rising edge after `sclk_i` rises, not earlier. `sdata_i` must be stable for three system clocks on either side of that rise, and each shift-clock level must last at least three system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low system reset, asynchronous |
| sclk_i | input | 1 | Serial shift clock from the host |
| sdata_i | input | 1 | Serial data, sampled on shift-clock rise |
| stb_ni | input | 1 | Active-low transparent strobe |
| clr_ni | input | 1 | Active-low clear, presets the output latch to ones |
| par_o | output | 24 | Parallel outputs |
| sout_o | output | 1 | Cascade output, last shift stage |

## Verification
A corrupted shift stage surfaces on `sout_o` exactly when it reaches stage 23. It appears on the parallel outputs four system clocks after the shift that creates it if the strobe is low, or at the next strobe otherwise. A latch controller stuck in the wrong state shows within about four system clocks. The outputs then fail to track shifts while strobed, move while they should hold, or leave the all-ones preset during clear. Clear leaking into the shift register shows only at the next strobe after release, so the bench shifts during clear and strobes afterwards. The chained pair exposes an off-by-one in the cascade timing, because the downstream device would collect a word shifted by one bit.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;

    // Shift-clock edge detector states
    typedef enum logic [0:0] {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_e;

    // Output latch controller states
    typedef enum logic [1:0] {
        LAT_CLEAR  = 2'd0,
        LAT_FOLLOW = 2'd1,
        LAT_HOLD   = 2'd2
    } lat_state_e;

endpackage

// File: rtl/sipo_in_sync.sv
module sipo_in_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic sdata_i,
    input  logic stb_ni,
    input  logic clr_ni,
    output logic sclk_s_o,
    output logic sdata_s_o,
    output logic stb_low_s_o,
    output logic clr_act_n_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sclk_q;
    logic [SYNC_STAGES-1:0] data_q;
    logic [SYNC_STAGES-1:0] stbn_q;
    logic [SYNC_STAGES-1:0] clr_q;
    logic                   clr_arst_n;

    // Clear asserts at once, releases through the synchroniser
    assign clr_arst_n = rst_ni & clr_ni;

    if (SYNC_STAGES > 1) begin : g_chain
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                sclk_q <= '0;
                data_q <= '0;
                stbn_q <= '1;
            end else begin
                sclk_q <= {sclk_q[LAST-1:0], sclk_i};
                data_q <= {data_q[LAST-1:0], sdata_i};
                stbn_q <= {stbn_q[LAST-1:0], stb_ni};
            end
        end

        always_ff @(posedge clk_i or negedge clr_arst_n) begin
            if (!clr_arst_n) begin
                clr_q <= '0;
            end else begin
                clr_q <= {clr_q[LAST-1:0], 1'b1};
            end
        end
    end else begin : g_single
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                sclk_q <= '0;
                data_q <= '0;
                stbn_q <= '1;
            end else begin
                sclk_q <= sclk_i;
                data_q <= sdata_i;
                stbn_q <= stb_ni;
            end
        end

        always_ff @(posedge clk_i or negedge clr_arst_n) begin
            if (!clr_arst_n) begin
                clr_q <= '0;
            end else begin
                clr_q <= 1'b1;
            end
        end
    end

    assign sclk_s_o    = sclk_q[LAST];
    assign sdata_s_o   = data_q[LAST];
    assign stb_low_s_o = ~stbn_q[LAST];
    assign clr_act_n_o = clr_q[LAST];

endmodule

// File: rtl/sipo_edge_fsm.sv
module sipo_edge_fsm
    import sipo_drv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_s_i,
    output logic shift_o
);

    ck_state_e state_q;
    ck_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_LOW:  if (sclk_s_i)  state_d = CK_HIGH;
            CK_HIGH: if (!sclk_s_i) state_d = CK_LOW;
            default: state_d = CK_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CK_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output: one pulse on the rise transition
    always_comb begin
        shift_o = 1'b0;
        unique case (state_q)
            CK_LOW:  shift_o = sclk_s_i;
            CK_HIGH: shift_o = 1'b0;
            default: shift_o = 1'b0;
        endcase
    end

    AST_ONE_SHIFT_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_o |=> !shift_o); // R2

endmodule

// File: rtl/sipo_shift_reg.sv
module sipo_shift_reg #(
    parameter int unsigned STAGES = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              shift_i,
    input  logic              din_i,
    output logic [STAGES-1:0] sreg_o
);

    logic [STAGES-1:0] sreg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sreg_q <= '0;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[STAGES-2:0], din_i};
        end
    end

    assign sreg_o = sreg_q;

    AST_STAGES_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> (sreg_o[STAGES-1:1] == $past(sreg_o[STAGES-2:0]))); // R2

    AST_NO_SHIFT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_i |=> $stable(sreg_o)); // R2

endmodule

// File: rtl/sipo_out_latch.sv
module sipo_out_latch
    import sipo_drv_pkg::*;
#(
    parameter int unsigned STAGES = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_act_ni,
    input  logic              stb_low_i,
    input  logic [STAGES-1:0] sreg_i,
    output logic [STAGES-1:0] par_o
);

    lat_state_e        state_q;
    lat_state_e        state_d;
    logic [STAGES-1:0] latch_q;
    logic              load_en;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_CLEAR:  state_d = stb_low_i ? LAT_FOLLOW : LAT_HOLD;
            LAT_FOLLOW: state_d = stb_low_i ? LAT_FOLLOW : LAT_HOLD;
            LAT_HOLD:   state_d = stb_low_i ? LAT_FOLLOW : LAT_HOLD;
            default:    state_d = LAT_HOLD;
        endcase
    end

    // State register, forced to clear asynchronously
    always_ff @(posedge clk_i or negedge clr_act_ni) begin
        if (!clr_act_ni) begin
            state_q <= LAT_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        load_en = 1'b0;
        unique case (state_q)
            LAT_CLEAR:  load_en = 1'b0;
            LAT_FOLLOW: load_en = 1'b1;
            LAT_HOLD:   load_en = 1'b0;
            default:    load_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge clr_act_ni) begin
        if (!clr_act_ni) begin
            latch_q <= '1;
        end else if (load_en) begin
            latch_q <= sreg_i;
        end
    end

    assign par_o = latch_q;

    AST_FOLLOW_TRACKS: assert property (@(posedge clk_i) disable iff (!clr_act_ni)
        (state_q == LAT_FOLLOW) |=> (par_o == $past(sreg_i))); // R3

    AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!clr_act_ni)
        (state_q == LAT_HOLD) |=> $stable(par_o)); // R4

    AST_CLEAR_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == LAT_CLEAR) |-> (par_o == {STAGES{1'b1}})); // R5

endmodule

// File: rtl/cascade_sipo_driver.sv
module cascade_sipo_driver
    import sipo_drv_pkg::*;
#(
    parameter int unsigned STAGES      = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              stb_ni,
    input  logic              clr_ni,
    output logic [STAGES-1:0] par_o,
    output logic              sout_o
);

    logic              sclk_s;
    logic              sdata_s;
    logic              stb_low_s;
    logic              clr_act_n;
    logic              shift;
    logic [STAGES-1:0] sreg;

    sipo_in_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_i      (sclk_i),
        .sdata_i     (sdata_i),
        .stb_ni      (stb_ni),
        .clr_ni      (clr_ni),
        .sclk_s_o    (sclk_s),
        .sdata_s_o   (sdata_s),
        .stb_low_s_o (stb_low_s),
        .clr_act_n_o (clr_act_n)
    );

    sipo_edge_fsm u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sclk_s_i (sclk_s),
        .shift_o  (shift)
    );

    sipo_shift_reg #(
        .STAGES (STAGES)
    ) u_sreg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (shift),
        .din_i   (sdata_s),
        .sreg_o  (sreg)
    );

    sipo_out_latch #(
        .STAGES (STAGES)
    ) u_latch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_act_ni (clr_act_n),
        .stb_low_i  (stb_low_s),
        .sreg_i     (sreg),
        .par_o      (par_o)
    );

    assign sout_o = sreg[STAGES-1];

    AST_SOUT_ONLY_ON_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift |=> $stable(sout_o)); // R7

endmodule

// File: tb/test_cascade_sipo_driver.sv
module test_cascade_sipo_driver;

    localparam int N = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sdata = 1'b0;
    logic         stb_n = 1'b1;
    logic         clr_n = 1'b1;
    logic [N-1:0] par;
    logic         sout;
    logic [N-1:0] par_dn;
    logic         sout_dn;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic [N-1:0] exp_sreg = '0;

    always #10 clk = ~clk;

    cascade_sipo_driver i_cascade_sipo_driver (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .sclk_i  (sclk),
        .sdata_i (sdata),
        .stb_ni  (stb_n),
        .clr_ni  (clr_n),
        .par_o   (par),
        .sout_o  (sout)
    );

    // Downstream device fed by the cascade output
    cascade_sipo_driver i_downstream (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .sclk_i  (sclk),
        .sdata_i (sout),
        .stb_ni  (stb_n),
        .clr_ni  (clr_n),
        .par_o   (par_dn),
        .sout_o  (sout_dn)
    );

    // {pattern sent MSB first, expected par_o after strobe, expected sout_o}
    localparam logic [48:0] VEC [4] = '{
        {24'hA5C33C, 24'hA5C33C, 1'b1},
        {24'h000001, 24'h000001, 1'b0},
        {24'hFFFFFE, 24'hFFFFFE, 1'b1},
        {24'h5A0F96, 24'h5A0F96, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string what, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        sdata = b;
        tick(5);
        sclk = 1'b1;
        tick(5);
        sclk = 1'b0;
        exp_sreg = {exp_sreg[N-2:0], b};
    endtask

    task automatic strobe();
        stb_n = 1'b0;
        tick(6);
        stb_n = 1'b1;
        tick(6);
    endtask

    initial begin
        logic [N-1:0] held;
        logic         old_sout;
        logic [47:0]  word;

        tick(4);
        rst_n = 1'b1;
        tick(3);
        // R9 reset state
        chk("R9 par after reset", 48'(par), 48'(24'hFFFFFF));
        chk("R9 sout after reset", 48'(sout), 48'd0);

        // Table walk: load with strobe high, then strobe
        for (int v = 0; v < 4; v++) begin
            held = par;
            for (int i = N - 1; i >= 0; i--) shift_bit(VEC[v][25 + i]);
            chk("R4 par held while shifting", 48'(par), 48'(held));
            chk("R7 sout is last stage", 48'(sout), 48'(VEC[v][0]));
            strobe();
            chk("R1 par after strobe", 48'(par), 48'(VEC[v][24:1]));
        end

        // R10 sout latency: rise at a negedge, new value on third posedge
        old_sout = sout;
        sdata = 1'b0;
        tick(5);
        sclk = 1'b1;
        tick(2);
        chk("R10 sout not yet updated", 48'(sout), 48'(old_sout));
        tick(1);
        chk("R10 sout updated", 48'(sout), 48'(exp_sreg[N-2]));
        tick(2);
        sclk = 1'b0;
        exp_sreg = {exp_sreg[N-2:0], 1'b0};
        tick(6);
        // R2 falling edge does not shift
        chk("R2 no shift on fall", 48'(sout), 48'(exp_sreg[N-1]));
        chk("R4 par held during shift", 48'(par), 48'(24'h5A0F96));

        // R3 follow mode
        stb_n = 1'b0;
        tick(6);
        chk("R3 par follows on strobe", 48'(par), 48'(exp_sreg));
        shift_bit(1'b1);
        chk("R3 par follows shift 1", 48'(par), 48'(exp_sreg));
        shift_bit(1'b0);
        chk("R3 par follows shift 2", 48'(par), 48'(exp_sreg));
        shift_bit(1'b1);
        chk("R2 R3 par follows shift 3", 48'(par), 48'(exp_sreg));

        // R5 clear overrides a low strobe, immediately
        clr_n = 1'b0;
        #1;
        chk("R5 par ones on clear", 48'(par), 48'(24'hFFFFFF));
        tick(1);
        shift_bit(1'b0);
        shift_bit(1'b1);
        chk("R5 par ones while shifting in clear", 48'(par), 48'(24'hFFFFFF));
        chk("R7 sout shifts during clear", 48'(sout), 48'(exp_sreg[N-1]));
        stb_n = 1'b1;
        tick(2);
        clr_n = 1'b1;
        tick(6);
        chk("R5 ones kept after release", 48'(par), 48'(24'hFFFFFF));
        stb_n = 1'b0;
        tick(6);
        chk("R6 shift register kept by clear", 48'(par), 48'(exp_sreg));
        stb_n = 1'b1;
        tick(4);

        // R8 cascade of two devices
        word = 48'h9C35_E1B6_4A27;
        for (int i = 47; i >= 0; i--) shift_bit(word[i]);
        strobe();
        chk("R8 downstream par", 48'(par_dn), 48'(word[47:24]));
        chk("R8 upstream par", 48'(par), 48'(word[23:0]));
        chk("R8 downstream sout", 48'(sout_dn), 48'(word[47]));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule